// File: doc/BRIEF.md
# HDLC Channel Host Register Front End

This block is the host-facing register window of one B-channel HDLC engine. The host sees two 32-bit locations. One is a control word on write and a status word on read. The other is a FIFO data port. A control write carries a command byte, a transmit block length and a mode byte. A status read returns the service causes, the receive state, the receive byte count and a fixed hardware version nibble. Behind the window sit a transmit pool and a receive pool, 32 bytes each by default. The host moves data through both pools one 32-bit word per access, with the lowest byte lane first in the stream.

The line side is a plain byte stream. A serial framer stands on the other side of it and handles flags, bit stuffing and CRC. That framer asks for transmit bytes one at a time and gets back the byte together with an end-of-frame marker. It pushes received bytes with an end marker and a three-bit check result. An internal test loop can route transmit bytes straight into the receive pool. A system with two channels places two copies of this block.

Top module: `hdlc_chan_regs`

## Requirements
- R1: After reset the status word reads only the version nibble in bits 27:24, irq is low, chanMode is 0 and a line request gets no valid byte.
- R2: A control write without the transmit-reset bit (command bit 7) starts a transmit block whose length is the byte in bits 15:8, where 0 means 32. Each FIFO write loads its byte lanes 0,1,2,3 in that order until the block length is reached, and the block discards lanes beyond it. The line side then receives the bytes in order, one per request, with lineTxValid high.
- R3: A FIFO read returns the next four receive bytes with the oldest byte in bits 7:0 and 0 in lanes past the stored count. Status bits 13:8 give the stored receive count, and a full pool of 32 reads as 0.
- R4: Status bit 7 (transmit pool ready) is set when the line side takes the last byte out of the transmit pool, and also by a transmit reset. irq is high whenever any of status bits 7:5 is set.
- R5: A status read clears status bits 7:5.
- R6: Status bit 6 (underrun) is set when the line side requests a byte while the transmit pool is empty and a frame is in progress. A frame is in progress once a byte has gone out, until its end-of-frame byte or an underrun. A request while idle sets nothing.
- R7: When mode bit 0 (framed mode) is set and command bit 0 marked the block, lineTxEof is high with the last byte of that block. With mode bit 1 (transparent) and bit 0 clear, lineTxEof stays low.
- R8: Status bit 5 (receive pool ready) is set when the receive pool becomes full. In framed mode it is also set when a byte with lineRxEnd arrives, and that byte sets status bit 0 and copies lineRxStat into status bits 3:1. In transparent mode the end marker is ignored.
- R9: A receive byte that arrives while the pool holds 32 bytes is dropped, sets status bit 4, and leaves the stored bytes unchanged.
- R10: A transmit reset (command bit 7) empties the transmit pool. A receive reset (command bit 5) empties the receive pool and clears status bits 13:8, 4, 3:1 and 0.
- R11: With mode bit 7 set, the transmit pool drains one byte per cycle into the receive pool, lineTxValid stays low, and a framed end-of-block byte completes a receive frame with status bits 3:1 equal to 3'b011.
- R12: The last written mode byte (control bits 23:16) is presented on chanMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | 0 selects the control/status word, 1 the FIFO data port |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe; read side effects occur at the clock edge |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for the selected location |
| irq | output | 1 | Service request, any cause bit pending |
| chanMode | output | 8 | Current mode byte for the line framer |
| lineTxReq | input | 1 | Line side asks for the next transmit byte |
| lineTxValid | output | 1 | A byte is delivered this cycle |
| lineTxData | output | 8 | Delivered transmit byte |
| lineTxEof | output | 1 | Delivered byte closes the frame |
| lineRxValid | input | 1 | Line side offers a received byte |
| lineRxData | input | 8 | Received byte |
| lineRxEnd | input | 1 | Received byte closes a frame |
| lineRxStat | input | 3 | Frame check result that comes with the end marker |

## Verification
The bench sweeps every transmit block length from 1 to 32 and every receive frame length from 1 to 32. It looks hardest at the length field where 0 means 32, at the partial last word and at the byte order inside a word. A design that got the encoding wrong would send nothing or 0 bytes for a full block. A design that got the word handling wrong would deliver extra bytes, or bytes in swapped lanes. The bench also requests a byte after the pool has run dry, both mid-frame and after a closed frame. A design that confused the two would either miss the underrun or raise false ones. Overflow, the reset commands, a transparent-mode end marker and the internal loop each get a directed check. A wrong design would then keep stale status, clobber stored bytes, or leak bytes onto the line during loop mode.

// File: rtl/hdlc_chan_pkg.sv
package hdlc_chan_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W = $clog2(WORD_BYTES + 1);

  // strobes from the control side to the FIFO datapath
  typedef struct packed {
    logic              txFlush;
    logic              rxFlush;
    logic [LANE_W-1:0] txPushN;
    logic              txPop;
    logic              rxPush;
    logic [7:0]        rxByte;
    logic [LANE_W-1:0] rxPopN;
  } pathCtl_t;
endpackage

// File: rtl/hdlc_byte_fifo.sv
module hdlc_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(PUSH_LANES + 1),
  localparam int QW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic [PW-1:0]           pushN,
  input  logic [8*PUSH_LANES-1:0] pushData,
  input  logic [QW-1:0]           popN,
  output logic [8*POP_LANES-1:0]  headData,
  output logic [CW-1:0]           count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_LANES; k++) begin
      if (!flush && PW'(k) < pushN) mem[wrPtr + AW'(k)] <= pushData[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushN);
      rdPtr <= rdPtr + AW'(popN);
      count <= count + CW'(pushN) - CW'(popN);
    end
  end

  // lanes past the stored count read as zero
  for (genvar k = 0; k < POP_LANES; k++) begin : g_head
    assign headData[8*k +: 8] = (CW'(k) < count) ? mem[rdPtr + AW'(k)] : 8'h00;
  end
endmodule

// File: rtl/hdlc_fifo_path.sv
module hdlc_fifo_path
  import hdlc_chan_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pathCtl_t                pathCtl,
  input  logic [8*WORD_BYTES-1:0] hostWdata,
  output logic [7:0]              txHead,
  output logic [CW-1:0]           txCount,
  output logic [8*WORD_BYTES-1:0] rxWord,
  output logic [CW-1:0]           rxCount
);
  hdlc_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(WORD_BYTES), .POP_LANES(1)) u_txPool (
    .clk(clk), .rstN(rstN), .flush(pathCtl.txFlush),
    .pushN(pathCtl.txPushN), .pushData(hostWdata),
    .popN(pathCtl.txPop), .headData(txHead), .count(txCount)
  );

  hdlc_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(WORD_BYTES)) u_rxPool (
    .clk(clk), .rstN(rstN), .flush(pathCtl.rxFlush),
    .pushN(pathCtl.rxPush), .pushData(pathCtl.rxByte),
    .popN(pathCtl.rxPopN), .headData(rxWord), .count(rxCount)
  );
endmodule

// File: rtl/hdlc_chan_ctrl.sv
module hdlc_chan_ctrl
  import hdlc_chan_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter logic [3:0] VERSION = 4'h3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostSel,
  input  logic                    hostWr,
  input  logic                    hostRd,
  input  logic                    wrTxRst,
  input  logic                    wrRxRst,
  input  logic                    wrEom,
  input  logic [7:0]              wrLen,
  input  logic [7:0]              wrMode,
  input  logic                    lineTxReq,
  input  logic                    lineRxValid,
  input  logic [7:0]              lineRxData,
  input  logic                    lineRxEnd,
  input  logic [2:0]              lineRxStat,
  input  logic [7:0]              txHead,
  input  logic [CW-1:0]           txCount,
  input  logic [8*WORD_BYTES-1:0] rxWord,
  input  logic [CW-1:0]           rxCount,
  output pathCtl_t                pathCtl,
  output logic [8*WORD_BYTES-1:0] hostRdata,
  output logic                    irq,
  output logic [7:0]              chanMode,
  output logic                    lineTxValid,
  output logic [7:0]              lineTxData,
  output logic                    lineTxEof
);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] LAST  = CW'(DEPTH - 1);
  localparam logic [CW-1:0] WB    = CW'(WORD_BYTES);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [7:0]    DEPTH8 = 8'(DEPTH);

  logic [7:0]    modeReg;
  logic [CW-1:0] loadLeft;
  logic          blockEom, eomArmed, txBusy;
  logic [2:0]    cause;   // {txReady, underrun, rxReady}
  logic          rdo, rme;
  logic [2:0]    rsta;

  logic ctlWr, fifoWr, statRd, fifoRd, txRst, rxRst, loopOn, hdlcOn;
  logic [CW-1:0] take, freeSpace, blockLen, rmlCount;
  logic [LANE_W-1:0] pushN, popWordN;
  logic blockDone, popReq, txEmpty, doPop, lastByte, frameEnd, underrun, drainEmpty;
  logic rxInValid, rxInEnd, rxAccept, rxDrop, endSeen, rprSet, xprSet;
  logic [7:0] rxInByte;
  logic [2:0] rxInStat;
  logic [31:0] statusWord;

  always_comb begin
    ctlWr  = hostWr & ~hostSel;
    fifoWr = hostWr & hostSel;
    statRd = hostRd & ~hostSel;
    fifoRd = hostRd & hostSel;
    txRst  = ctlWr & wrTxRst;
    rxRst  = ctlWr & wrRxRst;
    loopOn = modeReg[7];
    hdlcOn = modeReg[0];

    // transmit loading
    blockLen  = (wrLen == 8'h00 || wrLen > DEPTH8) ? FULL : CW'(wrLen);
    take      = (loadLeft < WB) ? loadLeft : WB;
    freeSpace = FULL - txCount;
    pushN     = '0;
    if (fifoWr) pushN = (take <= freeSpace) ? LANE_W'(take) : LANE_W'(freeSpace);
    blockDone = fifoWr && (loadLeft != '0) && (loadLeft <= WB);

    // transmit draining
    popReq     = loopOn ? 1'b1 : lineTxReq;
    txEmpty    = (txCount == '0);
    lastByte   = (txCount == ONE);
    doPop      = popReq & ~txEmpty & ~txRst;
    frameEnd   = doPop & lastByte & eomArmed & hdlcOn;
    underrun   = popReq & txEmpty & txBusy & ~txRst;
    drainEmpty = doPop & lastByte & (pushN == '0);
    xprSet     = drainEmpty | txRst;

    // receive source: line or internal loop
    rxInValid = loopOn ? doPop    : lineRxValid;
    rxInByte  = loopOn ? txHead   : lineRxData;
    rxInEnd   = loopOn ? frameEnd : lineRxEnd;
    rxInStat  = loopOn ? 3'b011   : lineRxStat;
    rxAccept  = rxInValid & (rxCount != FULL) & ~rxRst;
    rxDrop    = rxInValid & (rxCount == FULL) & ~rxRst;
    endSeen   = rxAccept & rxInEnd & hdlcOn;
    rprSet    = rxAccept & ((rxCount == LAST) | (rxInEnd & hdlcOn));
    popWordN  = '0;
    if (fifoRd) popWordN = (rxCount < WB) ? LANE_W'(rxCount) : LANE_W'(WB);

    pathCtl.txFlush = txRst;
    pathCtl.rxFlush = rxRst;
    pathCtl.txPushN = pushN;
    pathCtl.txPop   = doPop;
    pathCtl.rxPush  = rxAccept;
    pathCtl.rxByte  = rxInByte;
    pathCtl.rxPopN  = popWordN;

    rmlCount   = (rxCount == FULL) ? '0 : rxCount;
    statusWord = {4'h0, VERSION, 10'h000, 6'(rmlCount), cause, rdo, rsta, rme};
    hostRdata  = hostSel ? rxWord : statusWord;
  end

  assign irq         = |cause;
  assign chanMode    = modeReg;
  assign lineTxValid = doPop & ~loopOn;
  assign lineTxData  = txHead;
  assign lineTxEof   = frameEnd & ~loopOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      loadLeft <= '0;
      blockEom <= 1'b0;
      eomArmed <= 1'b0;
      txBusy   <= 1'b0;
      cause    <= '0;
      rdo      <= 1'b0;
      rme      <= 1'b0;
      rsta     <= '0;
    end else begin
      if (ctlWr) modeReg <= wrMode;

      if (txRst)       loadLeft <= '0;
      else if (ctlWr)  loadLeft <= blockLen;
      else if (fifoWr) loadLeft <= loadLeft - take;

      if (ctlWr && !wrTxRst) blockEom <= wrEom;

      if (txRst)                             eomArmed <= 1'b0;
      else if (blockDone && blockEom && hdlcOn) eomArmed <= 1'b1;
      else if (frameEnd)                     eomArmed <= 1'b0;

      if (txRst || underrun || frameEnd) txBusy <= 1'b0;
      else if (doPop)                    txBusy <= 1'b1;

      cause <= (statRd ? 3'b000 : cause) | {xprSet, underrun, rprSet};

      if (rxRst) begin
        rdo  <= 1'b0;
        rme  <= 1'b0;
        rsta <= '0;
      end else begin
        if (rxDrop) rdo <= 1'b1;
        if (endSeen) begin
          rme  <= 1'b1;
          rsta <= rxInStat;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_chan_regs.sv
module hdlc_chan_regs
  import hdlc_chan_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        irq,
  output logic [7:0]  chanMode,
  input  logic        lineTxReq,
  output logic        lineTxValid,
  output logic [7:0]  lineTxData,
  output logic        lineTxEof,
  input  logic        lineRxValid,
  input  logic [7:0]  lineRxData,
  input  logic        lineRxEnd,
  input  logic [2:0]  lineRxStat
);
  localparam int CW = $clog2(DEPTH + 1);

  pathCtl_t      pathCtl;
  logic [7:0]    txHead;
  logic [CW-1:0] txCount, rxCount;
  logic [31:0]   rxWord;

  hdlc_chan_ctrl #(.DEPTH(DEPTH), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .wrTxRst(hostWdata[7]), .wrRxRst(hostWdata[5]), .wrEom(hostWdata[0]),
    .wrLen(hostWdata[15:8]), .wrMode(hostWdata[23:16]),
    .lineTxReq(lineTxReq), .lineRxValid(lineRxValid), .lineRxData(lineRxData),
    .lineRxEnd(lineRxEnd), .lineRxStat(lineRxStat),
    .txHead(txHead), .txCount(txCount), .rxWord(rxWord), .rxCount(rxCount),
    .pathCtl(pathCtl), .hostRdata(hostRdata), .irq(irq), .chanMode(chanMode),
    .lineTxValid(lineTxValid), .lineTxData(lineTxData), .lineTxEof(lineTxEof)
  );

  hdlc_fifo_path #(.DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .pathCtl(pathCtl), .hostWdata(hostWdata),
    .txHead(txHead), .txCount(txCount), .rxWord(rxWord), .rxCount(rxCount)
  );
endmodule

// File: rtl/hdlc_chan_regs_chk.sv
module hdlc_chan_regs_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostSel,
  input logic          hostWr,
  input logic          txRstBit,
  input logic          rxRstBit,
  input logic          lineTxReq,
  input logic          lineTxValid,
  input logic          lineTxEof,
  input logic          loopBit,
  input logic          framedBit,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_valid_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lineTxValid |-> lineTxReq);

  p_loop_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    loopBit |-> !lineTxValid);

  p_eof_framed_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineTxEof |-> (lineTxValid && framedBit));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= FULL) && (txCount <= FULL));

  p_rx_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostSel && rxRstBit) |=> (rxCount == '0));

  p_tx_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostSel && txRstBit) |=> (txCount == '0));
endmodule

bind hdlc_chan_regs hdlc_chan_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
  .txRstBit(hostWdata[7]), .rxRstBit(hostWdata[5]),
  .lineTxReq(lineTxReq), .lineTxValid(lineTxValid), .lineTxEof(lineTxEof),
  .loopBit(chanMode[7]), .framedBit(chanMode[0]),
  .txCount(txCount), .rxCount(rxCount)
);

// File: tb/tb_hdlc_chan_regs.sv
module tb_hdlc_chan_regs;
  localparam logic [31:0] VER = 32'h0300_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic irq;
  logic [7:0] chanMode;
  logic lineTxReq = 1'b0;
  logic lineTxValid, lineTxEof;
  logic [7:0] lineTxData;
  logic lineRxValid = 1'b0, lineRxEnd = 1'b0;
  logic [7:0] lineRxData = '0;
  logic [2:0] lineRxStat = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdlc_chan_regs #(.DEPTH(32), .VERSION(4'h3)) dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq), .chanMode(chanMode),
    .lineTxReq(lineTxReq), .lineTxValid(lineTxValid), .lineTxData(lineTxData),
    .lineTxEof(lineTxEof), .lineRxValid(lineRxValid), .lineRxData(lineRxData),
    .lineRxEnd(lineRxEnd), .lineRxStat(lineRxStat)
  );

  function automatic logic [7:0] txPat(int l, int i);
    return 8'((l * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] rxPat(int n, int i);
    return 8'((n * 11 + i * 5 + 3) & 255);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // every task starts and ends on a falling edge
  task automatic ctlWrite(logic [7:0] mode, logic [7:0] len, logic [7:0] cmd);
    hostSel = 1'b0; hostWr = 1'b1; hostWdata = {8'h00, mode, len, cmd};
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic fifoWrite(logic [31:0] w);
    hostSel = 1'b1; hostWr = 1'b1; hostWdata = w;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic readStatus(output logic [31:0] v);
    hostSel = 1'b0; hostRd = 1'b1;
    #1 v = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic readFifo(output logic [31:0] v);
    hostSel = 1'b1; hostRd = 1'b1;
    #1 v = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic popByte(output logic v, output logic [7:0] d, output logic e);
    lineTxReq = 1'b1;
    #1 begin v = lineTxValid; d = lineTxData; e = lineTxEof; end
    @(negedge clk);
    lineTxReq = 1'b0;
  endtask

  task automatic rxByte(logic [7:0] d, logic e, logic [2:0] s);
    lineRxValid = 1'b1; lineRxData = d; lineRxEnd = e; lineRxStat = s;
    @(negedge clk);
    lineRxValid = 1'b0; lineRxEnd = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] s, w;
    logic v, e;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 chanMode", 32'(chanMode), 0);
    popByte(v, d, e);
    chk("R1 tx idle", 32'(v), 0);
    readStatus(s);
    chk("R1 status", s, VER);

    // R2/R7/R4 sweep of every block length in framed mode
    for (int l = 1; l <= 32; l++) begin
      ctlWrite(8'h01, 8'(l % 32), 8'h01);
      chk("R12 mode", 32'(chanMode), 32'h01);
      for (int wi = 0; wi < l / 4 + 1; wi++) begin
        for (int k = 0; k < 4; k++) w[8*k +: 8] = txPat(l, 4 * wi + k);
        fifoWrite(w);
      end
      for (int i = 0; i < l; i++) begin
        popByte(v, d, e);
        chk("R2 tx valid", 32'(v), 1);
        chk("R2 tx data", 32'(d), 32'(txPat(l, i)));
        chk("R7 tx eof", 32'(e), (i == l - 1) ? 1 : 0);
      end
      chk("R4 irq", 32'(irq), 1);
      readStatus(s);
      chk("R4 tx ready", s, VER | 32'h80);
      popByte(v, d, e);
      chk("R2 excess discarded", 32'(v), 0);
      readStatus(s);
      chk("R6 R5 idle request clean", s, VER);
    end

    // R6 underrun mid-frame in framed mode
    ctlWrite(8'h01, 8'd8, 8'h00);
    fifoWrite(32'h0403_0201);
    fifoWrite(32'h0807_0605);
    for (int i = 0; i < 8; i++) begin
      popByte(v, d, e);
      chk("R7 no eof without end mark", 32'(e), 0);
      chk("R2 data", 32'(d), 32'(i + 1));
    end
    popByte(v, d, e);
    chk("R6 empty request", 32'(v), 0);
    chk("R4 irq on underrun", 32'(irq), 1);
    readStatus(s);
    chk("R6 underrun", s, VER | 32'hC0);
    popByte(v, d, e);
    readStatus(s);
    chk("R6 single underrun", s, VER);

    // R7 transparent mode ignores end mark
    ctlWrite(8'h02, 8'd5, 8'h01);
    chk("R12 mode transparent", 32'(chanMode), 32'h02);
    fifoWrite(32'h4433_2211);
    fifoWrite(32'h8877_6655);
    for (int i = 0; i < 5; i++) begin
      popByte(v, d, e);
      chk("R7 transparent no eof", 32'(e), 0);
      chk("R2 transparent data", 32'(d), 32'(8'h11 * (i + 1)));
    end
    popByte(v, d, e);
    readStatus(s);
    chk("R6 transparent underrun", s, VER | 32'hC0);

    // R10 transmit reset
    ctlWrite(8'h01, 8'd8, 8'h00);
    fifoWrite(32'h0403_0201);
    fifoWrite(32'h0807_0605);
    ctlWrite(8'h01, 8'd0, 8'h80);
    popByte(v, d, e);
    chk("R10 tx flushed", 32'(v), 0);
    readStatus(s);
    chk("R4 R10 tx reset ready", s, VER | 32'h80);

    // R3/R8 sweep of every receive frame length
    ctlWrite(8'h01, 8'd0, 8'h20);
    readStatus(s);
    for (int n = 1; n <= 32; n++) begin
      for (int i = 0; i < n; i++) rxByte(rxPat(n, i), (i == n - 1), 3'(n));
      readStatus(s);
      chk("R8 R3 rx status", s, VER | (32'(n % 32) << 8) | 32'h21 | (32'(n % 8) << 1));
      for (int wi = 0; wi < (n + 3) / 4; wi++) begin
        readFifo(w);
        for (int k = 0; k < 4; k++) begin
          chk("R3 rx lane", 32'(w[8*k +: 8]),
              (4 * wi + k < n) ? 32'(rxPat(n, 4 * wi + k)) : 32'h0);
        end
      end
      ctlWrite(8'h01, 8'd0, 8'h20);
      readStatus(s);
      chk("R10 rx reset status", s, VER);
    end

    // R9 overflow
    for (int i = 0; i < 33; i++) rxByte(rxPat(40, i), 1'b0, 3'b000);
    readStatus(s);
    chk("R9 overflow status", s, VER | 32'h30);
    readFifo(w);
    chk("R9 stored bytes kept", w,
        {rxPat(40, 3), rxPat(40, 2), rxPat(40, 1), rxPat(40, 0)});
    ctlWrite(8'h01, 8'd0, 8'h20);
    readStatus(s);
    chk("R10 overflow cleared", s, VER);

    // R8 transparent receive ignores end mark
    ctlWrite(8'h02, 8'd0, 8'h20);
    for (int i = 0; i < 3; i++) rxByte(8'(i + 1), (i == 2), 3'b011);
    readStatus(s);
    chk("R8 transparent rx", s, VER | 32'h300);
    ctlWrite(8'h01, 8'd0, 8'h20);
    readStatus(s);

    // R11 internal loop
    ctlWrite(8'h81, 8'd0, 8'hA0);
    readStatus(s);
    ctlWrite(8'h81, 8'd6, 8'h01);
    chk("R12 mode loop", 32'(chanMode), 32'h81);
    lineTxReq = 1'b1;
    fifoWrite(32'hD4C3_B2A1);
    fifoWrite(32'h9988_F6E5);
    #1 chk("R11 line silent", 32'(lineTxValid), 0);
    repeat (10) @(negedge clk);
    lineTxReq = 1'b0;
    readStatus(s);
    chk("R11 loop status", s, VER | 32'h600 | 32'hA7);
    readFifo(w);
    chk("R11 loop word0", w, 32'hD4C3_B2A1);
    readFifo(w);
    chk("R11 loop word1", w, 32'h0000_F6E5);

    done = 1'b1;
    finishRun();
  end
endmodule